// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a 16-bit processor core and handles the interrupt side of its control flow. Devices post 16-bit messages into a message FIFO. When the core reports an instruction boundary and servicing is not deferred, the sequencer dequeues one message. If the handler-address register holds a nonzero value, the sequencer takes over a synchronous word memory port. It pushes the program counter and then the accumulator onto the stack, redirects the program counter to the handler, and places the message in the accumulator. Entering a handler sets the deferral flag, so later messages wait in the queue until the handler returns.

The core also hands four operations to the block: return from handler, set or clear deferral, read the handler address and write the handler address. Each takes a fixed number of cycles. The block holds `busy` high for exactly those cycles so that the core's fetch stage stalls. The core's stack pointer, program counter and accumulator are read through plain inputs and written back through write-strobe/value pairs.

Top module: `isr_sequencer`

## Requirements
- R1: After reset, `busy`, `deferred` and `fault` are 0, `ia_value` is 0 and the message FIFO is empty, so a handler address written after reset triggers no entry.
- R2: Handler entry writes the program counter to address SP-1 and then the accumulator to address SP-2, in two consecutive busy cycles, and leaves the stack pointer at SP-2.
- R3: In the second entry cycle the program counter is loaded with `ia_value` and the accumulator with the dequeued message.
- R4: Dequeuing a message sets `deferred`. While `deferred` is 1 no message is serviced, and queued messages are later serviced in arrival order.
- R5: A message dequeued while `ia_value` is 0 is discarded with no memory write, no register write and no change to `deferred`.
- R6: Return (`op_code` 0) occupies 3 busy cycles. It reads the accumulator from SP and the program counter from SP+1, leaves the stack pointer at SP+2 and clears `deferred`.
- R7: Read-address (`op_code` 2) occupies 1 busy cycle, with `op_done` high and `op_rdata` equal to `ia_value`. Write-address (`op_code` 3) occupies 1 busy cycle and loads `op_arg` into `ia_value`.
- R8: Queue control (`op_code` 1) occupies 2 busy cycles. It sets `deferred` when `op_arg` is nonzero and clears it when `op_arg` is zero.
- R9: A message is dequeued only while idle, with `boundary` high and no `op_valid`. An operation presented in the same cycle is served first.
- R10: The FIFO holds DEPTH (default 256) messages. A push while it is full is dropped and sets `fault`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Push a message into the FIFO |
| msg_data | input | 16 | Message word |
| boundary | input | 1 | Core is at an instruction boundary |
| op_valid | input | 1 | Core requests an operation (sampled when idle) |
| op_code | input | 2 | 0 return, 1 queue control, 2 read address, 3 write address |
| op_arg | input | 16 | Operand for queue control or write address |
| pc_in | input | 16 | Core program counter |
| acc_in | input | 16 | Core accumulator |
| sp_in | input | 16 | Core stack pointer |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| sp_wr | output | 1 | Stack-pointer write strobe |
| sp_out | output | 16 | New stack pointer |
| pc_wr | output | 1 | Program-counter write strobe |
| pc_out | output | 16 | New program counter |
| acc_wr | output | 1 | Accumulator write strobe |
| acc_out | output | 16 | New accumulator |
| op_done | output | 1 | Last cycle of an operation |
| op_rdata | output | 16 | Handler address for the read operation |
| busy | output | 1 | Stall the core's fetch stage |
| deferred | output | 1 | Servicing is deferred |
| ia_value | output | 16 | Handler-address register |
| fault | output | 1 | Sticky FIFO overflow |

## Verification
A deferral flag stuck low shows up within two cycles of the next queued message, as an unexpected entry that overwrites the handler's stack frame. A flag stuck high shows up as messages that are never serviced. A wrong stack offset or a swapped push order corrupts the return: the first return after that entry restores the wrong program counter or accumulator, three cycles after it starts. FIFO pointer faults show up as messages delivered out of order or lost, and this is visible in the accumulator at the next handler entry.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    OP_RETURN = 2'd0,
    OP_QUEUE  = 2'd1,
    OP_RDADDR = 2'd2,
    OP_WRADDR = 2'd3
  } isr_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ENT1,
    S_ENT2,
    S_RET1,
    S_RET2,
    S_RET3,
    S_Q1,
    S_Q2,
    S_RD,
    S_WR
  } seq_state_e;
endpackage

// File: rtl/isr_msg_fifo.sv
module isr_msg_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;
  logic          full, push_ok, pop_ok;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  // registered read port, updated only on a pop
  always_ff @(posedge clk) begin
    if (pop_ok) pop_data <= store[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      level <= level + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
  import isr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [DW-1:0] op_arg,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  input  logic          q_empty,
  input  logic [DW-1:0] q_data,
  output logic          q_pop,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_wr,
  output logic [DW-1:0] sp_out,
  output logic          pc_wr,
  output logic [DW-1:0] pc_out,
  output logic          acc_wr,
  output logic [DW-1:0] acc_out,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          busy,
  output logic          deferred,
  output logic [DW-1:0] ia_value
);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  seq_state_e    state;
  logic [DW-1:0] ia_q, sp_q, pc_q, acc_q;
  logic          defer_q;

  assign q_pop    = (state == S_IDLE) && !op_valid && boundary && !defer_q && !q_empty;
  assign deferred = defer_q;
  assign ia_value = ia_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ia_q    <= '0;
      defer_q <= 1'b0;
      sp_q    <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (op_valid) begin
            sp_q <= sp_in;
            unique case (isr_op_e'(op_code))
              OP_RETURN: state <= S_RET1;
              OP_QUEUE:  begin state <= S_Q1; defer_q <= |op_arg; end
              OP_RDADDR: state <= S_RD;
              OP_WRADDR: begin state <= S_WR; ia_q <= op_arg; end
            endcase
          end else if (q_pop) begin
            // a dequeue with no handler address is dropped silently
            if (ia_q != '0) begin
              state   <= S_ENT1;
              defer_q <= 1'b1;
              sp_q    <= sp_in;
              pc_q    <= pc_in;
              acc_q   <= acc_in;
            end
          end
        end
        S_ENT1: state <= S_ENT2;
        S_RET1: state <= S_RET2;
        S_RET2: state <= S_RET3;
        S_RET3: begin state <= S_IDLE; defer_q <= 1'b0; end
        S_Q1:   state <= S_Q2;
        default: state <= S_IDLE;
      endcase
    end
  end

  // outputs decode the registered state only
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    sp_wr     = 1'b0;
    sp_out    = '0;
    pc_wr     = 1'b0;
    pc_out    = '0;
    acc_wr    = 1'b0;
    acc_out   = '0;
    op_done   = 1'b0;
    op_rdata  = '0;
    busy      = (state != S_IDLE);
    unique case (state)
      S_ENT1: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - ONE;
        mem_wdata = pc_q;
      end
      S_ENT2: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - TWO;
        mem_wdata = acc_q;
        sp_wr     = 1'b1;
        sp_out    = sp_q - TWO;
        pc_wr     = 1'b1;
        pc_out    = ia_q;
        acc_wr    = 1'b1;
        acc_out   = q_data;
      end
      S_RET1: begin
        mem_re   = 1'b1;
        mem_addr = sp_q;
      end
      S_RET2: begin
        mem_re   = 1'b1;
        mem_addr = sp_q + ONE;
        acc_wr   = 1'b1;
        acc_out  = mem_rdata;
      end
      S_RET3: begin
        pc_wr   = 1'b1;
        pc_out  = mem_rdata;
        sp_wr   = 1'b1;
        sp_out  = sp_q + TWO;
        op_done = 1'b1;
      end
      S_Q2: op_done = 1'b1;
      S_RD: begin
        op_done  = 1'b1;
        op_rdata = ia_q;
      end
      S_WR: op_done = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer #(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msg_valid,
  input  logic [DW-1:0] msg_data,
  input  logic          boundary,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [DW-1:0] op_arg,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_wr,
  output logic [DW-1:0] sp_out,
  output logic          pc_wr,
  output logic [DW-1:0] pc_out,
  output logic          acc_wr,
  output logic [DW-1:0] acc_out,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          busy,
  output logic          deferred,
  output logic [DW-1:0] ia_value,
  output logic          fault
);
  logic          q_pop, q_empty;
  logic [DW-1:0] q_data;

  isr_msg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (msg_valid),
    .push_data (msg_data),
    .pop       (q_pop),
    .pop_data  (q_data),
    .empty     (q_empty),
    .overflow  (fault)
  );

  isr_seq_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_arg    (op_arg),
    .pc_in     (pc_in),
    .acc_in    (acc_in),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .q_empty   (q_empty),
    .q_data    (q_data),
    .q_pop     (q_pop),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_wr     (sp_wr),
    .sp_out    (sp_out),
    .pc_wr     (pc_wr),
    .pc_out    (pc_out),
    .acc_wr    (acc_wr),
    .acc_out   (acc_out),
    .op_done   (op_done),
    .op_rdata  (op_rdata),
    .busy      (busy),
    .deferred  (deferred),
    .ia_value  (ia_value)
  );
endmodule

// File: rtl/isr_sequencer_chk.sv
module isr_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic mem_we,
  input logic mem_re,
  input logic sp_wr,
  input logic pc_wr,
  input logic acc_wr,
  input logic op_done,
  input logic busy,
  input logic deferred,
  input logic fault
);
  // R2: the first push is always followed by the second push with the register loads
  p_push_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !pc_wr) |=> (mem_we && pc_wr && acc_wr && sp_wr));

  // R4: stack pushes only happen with servicing deferred
  p_push_deferred_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> deferred);

  // R6: first pop is followed by the accumulator load with the second read
  p_pop_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_re && !acc_wr) |=> (mem_re && acc_wr));

  // R6: second read is followed by the program counter and stack pointer writes
  p_pop_end_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_re && acc_wr) |=> (pc_wr && sp_wr && !mem_re && !mem_we));

  // R6: deferral is released after the return completes
  p_return_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && !mem_we) |=> !deferred);

  // R7: completion is only reported inside a busy window
  p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
    op_done |-> busy);

  // R10: fault stays set once raised
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R2: reads and writes never share a cycle
  p_port_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

bind isr_sequencer isr_sequencer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .sp_wr    (sp_wr),
  .pc_wr    (pc_wr),
  .acc_wr   (acc_wr),
  .op_done  (op_done),
  .busy     (busy),
  .deferred (deferred),
  .fault    (fault)
);

// File: tb/isr_sequencer_tb.sv
`timescale 1ns/1ps
module isr_sequencer_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          msg_valid;
  logic [DW-1:0] msg_data;
  logic          boundary;
  logic          op_valid;
  logic [1:0]    op_code;
  logic [DW-1:0] op_arg;
  logic [DW-1:0] mem_rdata;
  logic          mem_we, mem_re, sp_wr, pc_wr, acc_wr, op_done, busy, deferred, fault;
  logic [DW-1:0] mem_addr, mem_wdata, sp_out, pc_out, acc_out, op_rdata, ia_value;

  logic [DW-1:0] core_pc, core_acc, core_sp;
  logic [DW-1:0] smem [256];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  isr_sequencer #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_data(msg_data),
    .boundary(boundary), .op_valid(op_valid), .op_code(op_code), .op_arg(op_arg),
    .pc_in(core_pc), .acc_in(core_acc), .sp_in(core_sp), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_wr(sp_wr), .sp_out(sp_out), .pc_wr(pc_wr), .pc_out(pc_out),
    .acc_wr(acc_wr), .acc_out(acc_out), .op_done(op_done), .op_rdata(op_rdata),
    .busy(busy), .deferred(deferred), .ia_value(ia_value), .fault(fault)
  );

  // core registers and stack memory model
  always_ff @(posedge clk) begin
    if (rst) begin
      core_pc  <= 16'h0200;
      core_acc <= 16'h00AA;
      core_sp  <= 16'h0080;
    end else begin
      if (pc_wr)  core_pc  <= pc_out;
      if (acc_wr) core_acc <= acc_out;
      if (sp_wr)  core_sp  <= sp_out;
      if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= smem[mem_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] code, input logic [15:0] arg,
                       output int cycles, output logic [15:0] rd, output bit done_seen);
    op_valid = 1'b1; op_code = code; op_arg = arg;
    @(negedge clk);
    op_valid = 1'b0;
    cycles = 0; rd = '0; done_seen = 1'b0;
    while (busy && cycles < 20) begin
      if (op_done) begin done_seen = 1'b1; rd = op_rdata; end
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic push_msg(input logic [15:0] m);
    msg_valid = 1'b1; msg_data = m;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wait_entry(output int cyc);
    int n = 0;
    while (!busy && n < 8) begin @(negedge clk); n++; end
    cyc = 0;
    while (busy && cyc < 20) begin cyc++; @(negedge clk); end
  endtask

  task automatic quiet(input int n, output bit saw_busy);
    saw_busy = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (busy || mem_we) saw_busy = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    check(busy == 0 && deferred == 0 && fault == 0, "R1", "busy/deferred/fault",
          {busy, deferred, fault}, 0);
    check(ia_value == 0, "R1", "ia_value", ia_value, 0);
  endtask

  task automatic t_addr_ops();
    int c; logic [15:0] rd; bit d;
    do_op(2'd3, 16'h4000, c, rd, d);
    check(c == 1 && d, "R7", "write-address cycles", c, 1);
    check(ia_value == 16'h4000, "R7", "ia_value after write", ia_value, 16'h4000);
    do_op(2'd2, 16'h0, c, rd, d);
    check(c == 1 && d, "R7", "read-address cycles", c, 1);
    check(rd == 16'h4000, "R7", "read-address data", rd, 16'h4000);
  endtask

  task automatic t_entry();
    int c;
    push_msg(16'hBEEF);
    wait_entry(c);
    check(c == 2, "R2", "entry busy cycles", c, 2);
    check(smem[8'h7F] == 16'h0200, "R2", "pushed pc at sp-1", smem[8'h7F], 16'h0200);
    check(smem[8'h7E] == 16'h00AA, "R2", "pushed acc at sp-2", smem[8'h7E], 16'h00AA);
    check(core_sp == 16'h007E, "R2", "sp after entry", core_sp, 16'h007E);
    check(core_pc == 16'h4000, "R3", "pc = handler", core_pc, 16'h4000);
    check(core_acc == 16'hBEEF, "R3", "acc = message", core_acc, 16'hBEEF);
    check(deferred == 1, "R4", "deferred after entry", deferred, 1);
  endtask

  task automatic t_deferred_queue();
    bit sb;
    push_msg(16'h1111);
    push_msg(16'h2222);
    quiet(10, sb);
    check(!sb, "R4", "no entry while deferred", sb, 0);
    check(core_acc == 16'hBEEF, "R4", "acc untouched while deferred", core_acc, 16'hBEEF);
  endtask

  task automatic t_return(input logic [15:0] exp_acc, input logic [15:0] exp_pc);
    int c; logic [15:0] rd; bit d;
    do_op(2'd0, 16'h0, c, rd, d);
    check(c == 3 && d, "R6", "return cycles", c, 3);
    check(core_acc == exp_acc, "R6", "acc restored", core_acc, exp_acc);
    check(core_pc == exp_pc, "R6", "pc restored", core_pc, exp_pc);
    check(core_sp == 16'h0080, "R6", "sp restored", core_sp, 16'h0080);
    check(deferred == 0, "R6", "deferred cleared", deferred, 0);
  endtask

  task automatic t_queue_order();
    int c;
    t_return(16'h00AA, 16'h0200);
    wait_entry(c);
    check(c == 2 && core_acc == 16'h1111, "R4", "first queued message", core_acc, 16'h1111);
    t_return(16'h00AA, 16'h0200);
    wait_entry(c);
    check(c == 2 && core_acc == 16'h2222, "R4", "second queued message", core_acc, 16'h2222);
    t_return(16'h00AA, 16'h0200);
  endtask

  task automatic t_queue_ctl();
    int c; logic [15:0] rd; bit d, sb;
    do_op(2'd1, 16'h0001, c, rd, d);
    check(c == 2 && d, "R8", "queue-control cycles", c, 2);
    check(deferred == 1, "R8", "nonzero operand sets", deferred, 1);
    push_msg(16'h3333);
    quiet(6, sb);
    check(!sb, "R8", "held while set by operand", sb, 0);
    do_op(2'd1, 16'h0000, c, rd, d);
    check(c == 2 && deferred == 0, "R8", "zero operand clears", deferred, 0);
    wait_entry(c);
    check(core_acc == 16'h3333, "R8", "serviced after clear", core_acc, 16'h3333);
    t_return(16'h00AA, 16'h0200);
  endtask

  task automatic t_zero_addr();
    int c; logic [15:0] rd; bit d, sb;
    do_op(2'd3, 16'h0000, c, rd, d);
    push_msg(16'h5555);
    quiet(6, sb);
    check(!sb, "R5", "no entry with zero address", sb, 0);
    check(core_pc == 16'h0200 && core_acc == 16'h00AA && core_sp == 16'h0080, "R5",
          "core state unchanged", core_acc, 16'h00AA);
    check(deferred == 0, "R5", "deferred unchanged", deferred, 0);
    do_op(2'd3, 16'h4000, c, rd, d);
    quiet(6, sb);
    check(!sb, "R5", "discarded message not replayed", sb, 0);
  endtask

  task automatic t_boundary_prio();
    int c; logic [15:0] rd; bit d, sb;
    boundary = 1'b0;
    push_msg(16'h6666);
    quiet(6, sb);
    check(!sb, "R9", "held without boundary", sb, 0);
    boundary = 1'b1;
    wait_entry(c);
    check(c == 2 && core_acc == 16'h6666, "R9", "serviced at boundary", core_acc, 16'h6666);
    t_return(16'h00AA, 16'h0200);
    push_msg(16'h7777);
    do_op(2'd2, 16'h0, c, rd, d);
    check(c == 1 && rd == 16'h4000 && core_acc == 16'h00AA, "R9", "operation served first",
          core_acc, 16'h00AA);
    wait_entry(c);
    check(c == 2 && core_acc == 16'h7777, "R9", "message served after operation",
          core_acc, 16'h7777);
    t_return(16'h00AA, 16'h0200);
  endtask

  task automatic t_overflow();
    int c; logic [15:0] rd; bit d, sb;
    do_op(2'd1, 16'h0001, c, rd, d);
    for (int i = 0; i < DEPTH; i++) push_msg(16'(i));
    check(fault == 0, "R10", "no fault at DEPTH", fault, 0);
    push_msg(16'hFFFF);
    check(fault == 1, "R10", "fault on overflow", fault, 1);
    repeat (5) @(negedge clk);
    check(fault == 1, "R10", "fault sticky", fault, 1);
    apply_reset();
    check(fault == 0 && deferred == 0 && ia_value == 0, "R1", "reset clears fault/flags",
          {fault, deferred}, 0);
    do_op(2'd3, 16'h4000, c, rd, d);
    quiet(6, sb);
    check(!sb, "R1", "FIFO empty after reset", sb, 0);
  endtask

  initial begin
    msg_valid = 0; msg_data = 0; boundary = 1; op_valid = 0; op_code = 0; op_arg = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addr_ops();
    t_entry();
    t_deferred_queue();
    t_queue_order();
    t_queue_ctl();
    t_zero_addr();
    t_boundary_prio();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule